// File: doc/BRIEF.md
# Non-volatile wiper store sequencer

This block decides whether a freshly received wiper setting is committed to its non-volatile shadow copy, and runs the timed erase/write phase when it is. The serial front end pulses a frame-done strobe, with the channel address and the data byte, on the clock edge that takes in the last data bit. A store request on the program input is honoured only within a short arming window that opens on that edge; if no request arrives in time, the held setting is thrown away and must be sent again to be stored.

An accepted request starts a busy phase lasting a parameterised number of clock cycles. During this phase the ready flag is low and a blocking output tells the serial front end to ignore its data input and leave its data output undriven. At the end of the phase a one-cycle write strobe, with address and data, goes to the shadow register array. A supply-good input gates the start. When supply is low, the request is consumed, no busy phase runs and no write happens, so the ready flag stays high and shows that the store failed.

Top module: `nv_commit_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, ready_o is 1, serial_block_o is 0 and shadow_we_o is 0.
- R2: If prog_i is 1 on the same edge where frame_done_i is 1, and supply_ok_i is 1 and the block is idle, ready_o goes to 0 in the next cycle and stays 0 for exactly BUSY_CYCLES cycles.
- R3: If prog_i is 0 on the frame-done edge but is 1 on any of the following ARM_CYCLES-1 edges, the store is accepted with the address and data held from that frame.
- R4: If prog_i is first seen high after the arming window has closed, it is ignored. No busy phase starts, no strobe is issued, and the held value is discarded.
- R5: In the cycle where ready_o returns to 1, shadow_we_o is 1 for exactly one cycle. At that time shadow_addr_o and shadow_data_o equal the address and data of the accepted frame.
- R6: If supply_ok_i is 0 on the accepting edge, ready_o stays 1, no strobe follows, and the consumed request cannot be accepted again later.
- R7: While busy, frame_done_i and prog_i have no effect. The timer does not restart, and the strobed value is the one accepted first.
- R8: serial_block_o is 1 exactly in the cycles where ready_o is 0.
- R9: A new frame-done pulse that arrives while the window is open replaces the held address and data and restarts the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock, kept running through the store |
| rst | input | 1 | Synchronous active-high reset |
| prog_i | input | 1 | Store request level |
| frame_done_i | input | 1 | One-cycle pulse on the edge of the last data bit |
| frame_addr_i | input | ADDR_W | Channel address of the finished frame |
| frame_data_i | input | DATA_W | Wiper value of the finished frame |
| supply_ok_i | input | 1 | Supply high enough to program |
| shadow_we_o | output | 1 | One-cycle write strobe to the shadow array |
| shadow_addr_o | output | ADDR_W | Channel address for the shadow write |
| shadow_data_o | output | DATA_W | Value for the shadow write |
| ready_o | output | 1 | 1 when ready, 0 while erase/write is busy |
| serial_block_o | output | 1 | Tells the serial front end to ignore its input and float its output |

## Verification
All outputs come from registers. An input applied before edge E therefore shows at the outputs in the cycle after E: the busy flag falls one cycle after the accepting edge, and the strobe appears BUSY_CYCLES cycles after that, together with the ready flag rising. The bench drives inputs on the falling edge, advances a cycle-level reference model at the same moment, and compares every output at the next falling edge. Each result is then checked in exactly the cycle it is due. Directed cases count strobes and check their payload at the end of each case.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  // width of a down-counter that must hold values 0..n-1
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // what happens to a store request on a given edge
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_START = 2'd1,
    ACT_DROP  = 2'd2
  } commit_act_e;

endpackage

// File: rtl/nvs_arm_window.sv
module nvs_arm_window
  import nvs_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 8,
  parameter int ARM_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_done_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              prog_i,
  input  logic              hold_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_data_o
);

  localparam int CW = cnt_width(ARM_CYCLES - 1);

  logic              armed;
  logic [CW-1:0]     left;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;

  // the frame-done edge itself is the first edge of the window
  assign req_o      = !hold_i && prog_i && (frame_done_i || armed);
  assign req_addr_o = frame_done_i ? addr_i : pend_addr;
  assign req_data_o = frame_done_i ? data_i : pend_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      left      <= '0;
      pend_addr <= '0;
      pend_data <= '0;
    end else if (hold_i) begin
      armed <= 1'b0;
    end else if (frame_done_i && !prog_i) begin
      pend_addr <= addr_i;
      pend_data <= data_i;
      armed     <= 1'b1;
      left      <= CW'(ARM_CYCLES - 2);
    end else if (req_o) begin
      armed <= 1'b0;
    end else if (armed) begin
      if (left == '0) armed <= 1'b0;
      else            left  <= left - 1'b1;
    end
  end

  // R4
  window_expire_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && left == '0 && !frame_done_i) |=> !armed);

endmodule

// File: rtl/nvs_busy_timer.sv
module nvs_busy_timer
  import nvs_pkg::*;
#(
  parameter int BUSY_CYCLES = 200000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);

  localparam int CW = cnt_width(BUSY_CYCLES);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      remain <= '0;
    end else begin
      done_o <= 1'b0;
      if (busy_o) begin
        if (remain == '0) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          remain <= remain - 1'b1;
        end
      end else if (start_i) begin
        busy_o <= 1'b1;
        remain <= CW'(BUSY_CYCLES - 1);
      end
    end
  end

  // R2
  start_enters_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (busy_o && !done_o));

  // R7
  busy_no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && remain != '0) |=> (busy_o && remain == $past(remain) - 1'b1));

endmodule

// File: rtl/nv_commit_seq.sv
module nv_commit_seq
  import nvs_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8,
  parameter int ARM_CYCLES  = 2,
  parameter int BUSY_CYCLES = 200000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_i,
  input  logic              frame_done_i,
  input  logic [ADDR_W-1:0] frame_addr_i,
  input  logic [DATA_W-1:0] frame_data_i,
  input  logic              supply_ok_i,
  output logic              shadow_we_o,
  output logic [ADDR_W-1:0] shadow_addr_o,
  output logic [DATA_W-1:0] shadow_data_o,
  output logic              ready_o,
  output logic              serial_block_o
);

  logic              busy;
  logic              done;
  logic              req;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_data;
  commit_act_e       act;

  nvs_arm_window #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .ARM_CYCLES(ARM_CYCLES)
  ) u_window (
    .clk         (clk),
    .rst         (rst),
    .frame_done_i(frame_done_i),
    .addr_i      (frame_addr_i),
    .data_i      (frame_data_i),
    .prog_i      (prog_i),
    .hold_i      (busy),
    .req_o       (req),
    .req_addr_o  (req_addr),
    .req_data_o  (req_data)
  );

  always_comb begin
    act = ACT_NONE;
    if (req && !busy) act = supply_ok_i ? ACT_START : ACT_DROP;
  end

  nvs_busy_timer #(
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start_i(act == ACT_START),
    .busy_o (busy),
    .done_o (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_addr_o <= '0;
      shadow_data_o <= '0;
    end else if (act == ACT_START) begin
      shadow_addr_o <= req_addr;
      shadow_data_o <= req_data;
    end
  end

  assign shadow_we_o    = done;
  assign ready_o        = !busy;
  assign serial_block_o = busy;

  // R6
  drop_keeps_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_DROP) |=> ready_o);

  // R7
  busy_holds_value_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready_o) |=> ($stable(shadow_data_o) && $stable(shadow_addr_o)));

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    shadow_we_o |=> !shadow_we_o);

  // R5
  strobe_at_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> shadow_we_o);

endmodule

// File: tb/nv_commit_seq_bench.sv
module nv_commit_seq_bench;

  localparam int AW   = 2;
  localparam int DW   = 8;
  localparam int ARM  = 2;
  localparam int BUSY = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          prog_i = 1'b0;
  logic          frame_done_i = 1'b0;
  logic [AW-1:0] frame_addr_i = '0;
  logic [DW-1:0] frame_data_i = '0;
  logic          supply_ok_i = 1'b1;
  logic          shadow_we_o;
  logic [AW-1:0] shadow_addr_o;
  logic [DW-1:0] shadow_data_o;
  logic          ready_o;
  logic          serial_block_o;

  always #10 clk = ~clk;

  nv_commit_seq #(
    .ADDR_W(AW), .DATA_W(DW), .ARM_CYCLES(ARM), .BUSY_CYCLES(BUSY)
  ) u_nv_commit_seq (
    .clk(clk), .rst(rst), .prog_i(prog_i), .frame_done_i(frame_done_i),
    .frame_addr_i(frame_addr_i), .frame_data_i(frame_data_i),
    .supply_ok_i(supply_ok_i), .shadow_we_o(shadow_we_o),
    .shadow_addr_o(shadow_addr_o), .shadow_data_o(shadow_data_o),
    .ready_o(ready_o), .serial_block_o(serial_block_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int strobes = 0;
  string cur_req = "R1";

  // reference model state (after the last edge)
  logic          m_busy = 0, m_armed = 0, m_we = 0;
  int            m_cnt = 0, m_left = 0;
  logic [AW-1:0] m_pa = '0, m_ca = '0;
  logic [DW-1:0] m_pd = '0, m_cd = '0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_step(input logic fd, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input logic pg, input logic sok);
    logic req;
    logic [AW-1:0] ra;
    logic [DW-1:0] rd;
    req = !m_busy && pg && (fd || m_armed);
    ra  = fd ? a : m_pa;
    rd  = fd ? d : m_pd;
    if (m_busy) m_armed = 0;
    else if (fd && !pg) begin m_pa = a; m_pd = d; m_armed = 1; m_left = ARM - 2; end
    else if (req) m_armed = 0;
    else if (m_armed) begin
      if (m_left == 0) m_armed = 0; else m_left--;
    end
    m_we = 0;
    if (m_busy) begin
      if (m_cnt == 0) begin m_busy = 0; m_we = 1; end else m_cnt--;
    end else if (req && sok) begin
      m_busy = 1; m_cnt = BUSY - 1; m_ca = ra; m_cd = rd;
    end
  endtask

  // drive at a falling edge, then compare at the next falling edge
  task automatic cyc(input logic fd, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input logic pg, input logic sok);
    frame_done_i = fd; frame_addr_i = a; frame_data_i = d;
    prog_i = pg; supply_ok_i = sok;
    model_step(fd, a, d, pg, sok);
    @(negedge clk);
    if (shadow_we_o) strobes++;
    chk({cur_req, " ready"}, ready_o, !m_busy);
    chk("R8 block", serial_block_o, m_busy);
    chk({cur_req, " strobe"}, shadow_we_o, m_we);
    if (m_we) begin
      chk("R5 addr", shadow_addr_o, m_ca);
      chk("R5 data", shadow_data_o, m_cd);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, '0, '0, 0, 1);
  endtask

  int s0;
  int low_cnt;

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ready", ready_o, 1);
    chk("R1 block", serial_block_o, 0);
    chk("R1 strobe", shadow_we_o, 0);
    rst = 1'b0;
    idle(1);

    // R2: request on the frame edge, count busy cycles
    cur_req = "R2"; s0 = strobes; low_cnt = 0;
    cyc(1, 2'd1, 8'hA5, 1, 1);
    for (int i = 0; i < BUSY + 3; i++) begin
      if (!ready_o) low_cnt++;
      idle(1);
    end
    chk("R2 busy length", low_cnt, BUSY);
    chk("R5 strobe count", strobes - s0, 1);
    chk("R5 payload", shadow_data_o, 8'hA5);

    // R3: request on the second window edge
    cur_req = "R3"; s0 = strobes;
    cyc(1, 2'd2, 8'h3C, 0, 1);
    cyc(0, 2'd0, 8'h00, 1, 1);
    idle(BUSY + 3);
    chk("R3 strobe count", strobes - s0, 1);
    chk("R3 payload", shadow_data_o, 8'h3C);
    chk("R3 addr", shadow_addr_o, 2);

    // R4: request after the window closed
    cur_req = "R4"; s0 = strobes;
    cyc(1, 2'd3, 8'hFF, 0, 1);
    cyc(0, 2'd0, 8'h00, 0, 1);
    for (int i = 0; i < 4; i++) cyc(0, '0, '0, 1, 1);
    idle(BUSY + 3);
    chk("R4 strobe count", strobes - s0, 0);
    chk("R4 value kept", shadow_data_o, 8'h3C);

    // R6: supply low on the accepting edge, then retry prog
    cur_req = "R6"; s0 = strobes;
    cyc(1, 2'd0, 8'h11, 1, 0);
    chk("R6 ready", ready_o, 1);
    cyc(0, 2'd0, 8'h00, 1, 1);
    idle(BUSY + 3);
    chk("R6 strobe count", strobes - s0, 0);

    // R7: new frame and prog while busy
    cur_req = "R7"; s0 = strobes;
    cyc(1, 2'd1, 8'h00, 1, 1);
    idle(3);
    cyc(1, 2'd2, 8'h77, 1, 1);
    cyc(0, 2'd0, 8'h00, 1, 1);
    idle(BUSY + 3);
    chk("R7 strobe count", strobes - s0, 1);
    chk("R7 payload", shadow_data_o, 8'h00);

    // R9: second frame inside the window replaces the first
    cur_req = "R9"; s0 = strobes;
    cyc(1, 2'd0, 8'h01, 0, 1);
    cyc(1, 2'd3, 8'h02, 0, 1);
    cyc(0, 2'd0, 8'h00, 1, 1);
    idle(BUSY + 3);
    chk("R9 strobe count", strobes - s0, 1);
    chk("R9 payload", shadow_data_o, 8'h02);
    chk("R9 addr", shadow_addr_o, 3);

    // random phase, every output compared each cycle
    cur_req = "R2/R3/R4 random";
    for (int i = 0; i < 3000; i++) begin
      logic fd, pg, sok;
      fd  = ($urandom % 6) == 0;
      pg  = ($urandom % 3) == 0;
      sok = ($urandom % 8) != 0;
      cyc(fd, AW'($urandom), DW'($urandom), pg, sok);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule